// File: doc/BRIEF.md
# Page Write Collector for a Serial Nonvolatile Memory

This block sits between the byte-level serial protocol engine and the memory array of a small serial nonvolatile memory. Once the protocol engine has decoded a word address, it sends each following write byte to this block. The block stores each byte in a page buffer. The page buffer holds 16 bytes by default. The upper address bits choose the page and stay fixed. The low in-page offset advances after every byte and wraps at the page end, so a later byte that lands on an offset already written replaces the earlier byte.

Nothing reaches the array until a stop event arrives. At that point the block drives a one-cycle masked page write. The mask carries only the offsets that actually received data. The block then raises `busy` for a write-cycle time, counted in system clock cycles. While `busy` is high it ignores every input strobe.

The block also keeps the shared address pointer and moves it after the write, using rules that depend on the byte count. A stop that follows only an address (a pointer-setting dummy write) starts no write. A stop seen while the low-supply flag is high also starts no write.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `wr_en` is 0 and `ptr` is 0.
- R2: An accepted `addr_load` sets `ptr` to `addr_in` in the next cycle and opens a fill. Each accepted `data_vld` byte is stored at the current in-page offset. The offset starts at `addr_in[3:0]` and advances by one per byte, wrapping from 15 to 0. The page number is `addr_in[8:4]`; it is reported on `wr_page` and never changes during the fill.
- R3: When more bytes arrive than fit before the offset comes back around, a repeated offset holds the last byte written to it.
- R4: `wr_en` stays 0 until a stop event. The stop produces exactly one `wr_en` cycle, and `busy` rises in that same cycle. Bit i of `wr_mask` is 1 exactly when offset i received a byte, and `wr_data[8*i+7:8*i]` holds that byte.
- R5: `busy` stays high for exactly `WC_CYCLES` clock cycles after a commit. While it is high, `addr_load`, `data_vld` and `stop_evt` have no effect: no `wr_en`, and `ptr` does not change.
- R6: After a commit of 1 to 15 bytes, `ptr` is {page, (start offset + byte count) mod 16}. For example, one byte at offset 15 leaves the pointer at offset 0 of the same page.
- R7: After a commit of 16 or more bytes, `ptr` equals the start address given with `addr_load`.
- R8: If `low_supply` is 1 when the stop event arrives, no `wr_en` is issued, `busy` stays 0, and `ptr` keeps the loaded start address.
- R9: A stop after an address with no data bytes issues no `wr_en` and leaves `busy` at 0. `ptr` keeps the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Word address strobe from the protocol engine |
| addr_in | input | ADDR_W | Word address that goes with `addr_load` |
| data_vld | input | 1 | Write data byte strobe |
| data_in | input | 8 | Write data byte |
| stop_evt | input | 1 | Stop condition event |
| low_supply | input | 1 | Supply-too-low flag; blocks the start of a write |
| busy | output | 1 | Write cycle in progress |
| ptr | output | ADDR_W | Shared address pointer |
| wr_en | output | 1 | One-cycle page write strobe to the array |
| wr_page | output | ADDR_W-PAGE_W | Page number of the write |
| wr_data | output | 8*2^PAGE_W | Page buffer contents, byte i at bits 8i+7:8i |
| wr_mask | output | 2^PAGE_W | Byte enables for the page write |

## Verification
Most wrong internal states in this block show up at the ports in the very cycle `wr_en` pulses. An offset counter that drifts or touches upper address bits puts a byte at the wrong `wr_data` lane or sets the wrong `wr_mask` bit. A mis-kept byte count lands `ptr` on the wrong post-write address, and it does so in that same cycle. Timer faults appear as a `busy` window whose length differs from `WC_CYCLES`. A bad input gate appears as a stray `wr_en` or a moved `ptr` inside the busy window. A pointer fault in a dummy write or low-supply stop appears one cycle after the stop.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_t;

  // Post-write in-page offset: wrapped start+count below a full page, start otherwise.
  function automatic int post_off(input int start_off, input int count, input int pw);
    int page_len;
    page_len = 1 << pw;
    if (count >= page_len) return start_off;
    return (start_off + count) % page_len;
  endfunction

  // Received-byte count that stops growing once a full page has been seen.
  function automatic int count_sat(input int count, input int pw);
    if (count >= (1 << pw)) return count;
    return count + 1;
  endfunction

endpackage

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE = 1 << PAGE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [PAGE_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [PAGE*DATA_W-1:0]   page_o,
  output logic [PAGE-1:0]          mask_o
);

  for (genvar g = 0; g < PAGE; g++) begin : g_entry
    logic [DATA_W-1:0] entry;
    logic              vld;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry <= '0;
        vld   <= 1'b0;
      end else if (clr) begin
        vld   <= 1'b0;
      end else if (we && waddr == PAGE_W'(g)) begin
        entry <= wdata;
        vld   <= 1'b1;
      end
    end
    assign page_o[g*DATA_W +: DATA_W] = entry;
    assign mask_o[g]                  = vld;
  end

  // R4: a written entry is flagged for commit
  a_r4_mask_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> mask_o[$past(waddr)]);

  // R3: the latest byte to an entry is the one held
  a_r3_last_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> page_o[$past(waddr)*DATA_W +: DATA_W] == $past(wdata));

  // R2: a fresh fill starts with an empty mask
  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> mask_o == '0);

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WC_CYCLES = 1000000,
  localparam int CW = $clog2(WC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(WC_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R5: a write cycle is never restarted from inside another
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R5: a start always produces a busy window
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WC_CYCLES = 1000000,
  localparam int PAGE     = 1 << PAGE_W,
  localparam int PG_W     = ADDR_W - PAGE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_load,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic                 data_vld,
  input  logic [7:0]           data_in,
  input  logic                 stop_evt,
  input  logic                 low_supply,
  output logic                 busy,
  output logic [ADDR_W-1:0]    ptr,
  output logic                 wr_en,
  output logic [PG_W-1:0]      wr_page,
  output logic [PAGE*8-1:0]    wr_data,
  output logic [PAGE-1:0]      wr_mask
);

  fill_state_t         state;
  logic [ADDR_W-1:0]   start_addr;
  logic [PAGE_W-1:0]   off;
  logic [PAGE_W:0]     cnt;

  // Named internal events
  logic ev_load, ev_byte, ev_stop, ev_commit;
  logic [PAGE_W-1:0] new_off;
  logic [PAGE_W:0]   cnt_next;

  assign ev_load   = addr_load && !busy;
  assign ev_byte   = data_vld && !busy && !addr_load && (state == ST_FILL);
  assign ev_stop   = stop_evt && !busy && !addr_load && !data_vld && (state == ST_FILL);
  assign ev_commit = ev_stop && (cnt != '0) && !low_supply;

  assign new_off  = PAGE_W'(post_off(int'(start_addr[PAGE_W-1:0]), int'(cnt), PAGE_W));
  assign cnt_next = (PAGE_W+1)'(count_sat(int'(cnt), PAGE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      start_addr <= '0;
      off        <= '0;
      cnt        <= '0;
      ptr        <= '0;
      wr_en      <= 1'b0;
    end else begin
      wr_en <= ev_commit;
      if (ev_load) begin
        state      <= ST_FILL;
        start_addr <= addr_in;
        off        <= addr_in[PAGE_W-1:0];
        cnt        <= '0;
        ptr        <= addr_in;
      end else if (ev_byte) begin
        off <= off + 1'b1;
        cnt <= cnt_next;
      end else if (ev_stop) begin
        state <= ST_IDLE;
        if (ev_commit) ptr <= {start_addr[ADDR_W-1:PAGE_W], new_off};
      end
    end
  end

  assign wr_page = start_addr[ADDR_W-1:PAGE_W];

  pgwr_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ev_load),
    .we     (ev_byte),
    .waddr  (off),
    .wdata  (data_in),
    .page_o (wr_data),
    .mask_o (wr_mask)
  );

  pgwr_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_commit),
    .busy  (busy)
  );

  // R4: the commit strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4: busy rises together with the commit
  a_r4_busy_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R4: a commit always carries at least one received byte
  a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_mask != '0);

  // R5: no commit is launched while a write cycle runs
  a_r5_no_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(busy));

  // R5: the pointer is frozen during a write cycle
  a_r5_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ptr));

  // R8: low supply at the stop blocks the commit
  a_r8_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(low_supply));

  // R9: a stop with no data starts no write cycle
  a_r9_dummy_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && cnt == '0) |=> !busy && !wr_en);

  // R2: the offset changes only on load or byte events
  a_r2_offset_moves_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_byte) |=> $stable(off));

endmodule

// File: tb/sim_pgwr_ctrl.sv
`timescale 1ns/1ps
module sim_pgwr_ctrl;

  localparam int AW = 9;
  localparam int PW = 4;
  localparam int WC = 20;
  localparam int PG = 1 << PW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           addr_load = 1'b0;
  logic [AW-1:0]  addr_in = '0;
  logic           data_vld = 1'b0;
  logic [7:0]     data_in = '0;
  logic           stop_evt = 1'b0;
  logic           low_supply = 1'b0;
  logic           busy;
  logic [AW-1:0]  ptr;
  logic           wr_en;
  logic [AW-PW-1:0] wr_page;
  logic [PG*8-1:0]  wr_data;
  logic [PG-1:0]    wr_mask;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pgwr_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .WC_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .data_vld(data_vld), .data_in(data_in), .stop_evt(stop_evt),
    .low_supply(low_supply), .busy(busy), .ptr(ptr), .wr_en(wr_en),
    .wr_page(wr_page), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); data_vld = 1'b1; data_in = d;
    @(negedge clk); data_vld = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  // Generic write with a bench-side page model.
  task automatic run_write(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                           input bit low, input string req);
    logic [7:0]     ebuf [PG];
    logic [PG-1:0]  emask;
    logic [AW-1:0]  eptr;
    int             soff;
    int             bcnt;
    emask = '0;
    soff  = int'(a) % PG;
    for (int i = 0; i < PG; i++) ebuf[i] = 8'h00;
    load_addr(a);
    chk(ptr == a, {req, " R2 ptr after load"}, 32'(ptr), 32'(a));
    for (int i = 0; i < n; i++) begin
      int o;
      o = (soff + i) % PG;
      ebuf[o] = seed + 8'(i * 7);
      emask[o] = 1'b1;
      send_byte(ebuf[o]);
    end
    chk(wr_en == 1'b0, {req, " R4 no commit before stop"}, 32'(wr_en), 0);
    low_supply = low;
    send_stop();
    low_supply = 1'b0;
    if (n == 0 || low) begin
      chk(wr_en == 1'b0, {req, " R8/R9 no commit"}, 32'(wr_en), 0);
      chk(busy == 1'b0, {req, " R8/R9 not busy"}, 32'(busy), 0);
      chk(ptr == a, {req, " R8/R9 ptr kept"}, 32'(ptr), 32'(a));
    end else begin
      if (n >= PG) eptr = a;
      else eptr = AW'((int'(a) / PG) * PG + (soff + n) % PG);
      chk(wr_en == 1'b1, {req, " R4 commit strobe"}, 32'(wr_en), 1);
      chk(busy == 1'b1, {req, " R4 busy with commit"}, 32'(busy), 1);
      chk(wr_page == a[AW-1:PW], {req, " R2 page"}, 32'(wr_page), 32'(a[AW-1:PW]));
      chk(wr_mask == emask, {req, " R4 mask"}, 32'(wr_mask), 32'(emask));
      for (int i = 0; i < PG; i++)
        if (emask[i])
          chk(wr_data[i*8 +: 8] == ebuf[i], {req, " R3 data lane"}, 32'(wr_data[i*8 +: 8]), 32'(ebuf[i]));
      chk(ptr == eptr, {req, (n >= PG) ? " R7 ptr" : " R6 ptr"}, 32'(ptr), 32'(eptr));
      bcnt = 0;
      while (busy) begin
        bcnt++;
        @(negedge clk);
        if (wr_en) chk(1'b0, {req, " R4 extra strobe"}, 1, 0);
      end
      chk(bcnt == WC, {req, " R5 busy length"}, 32'(bcnt), 32'(WC));
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(wr_en == 1'b0, "R1 wr_en", 32'(wr_en), 0);
    chk(ptr == '0, "R1 ptr", 32'(ptr), 0);
  endtask

  task automatic t_single();   run_write(9'h123, 1, 8'h5A, 1'b0, "single"); endtask
  task automatic t_partial();  run_write(9'h0AC, 7, 8'h10, 1'b0, "wrap7"); endtask
  task automatic t_full();     run_write(9'h1F5, 16, 8'h80, 1'b0, "full16"); endtask
  task automatic t_overflow(); run_write(9'h047, 19, 8'h33, 1'b0, "over19"); endtask
  task automatic t_last_off(); run_write(9'h13F, 1, 8'hC4, 1'b0, "off15"); endtask
  task automatic t_dummy();    run_write(9'h088, 0, 8'h00, 1'b0, "dummy R9"); endtask
  task automatic t_low();      run_write(9'h050, 3, 8'h21, 1'b1, "lowsup R8"); endtask

  task automatic t_busy_ignore();
    int strobes;
    logic [AW-1:0] held;
    load_addr(9'h025);
    send_byte(8'hA1);
    send_byte(8'hA2);
    send_stop();
    held = ptr;
    chk(held == 9'h027, "R6 ptr before busy probe", 32'(held), 32'h027);
    strobes = 0;
    @(negedge clk); addr_load = 1'b1; addr_in = 9'h1A0;
    @(negedge clk); addr_load = 1'b0; data_vld = 1'b1; data_in = 8'hEE;
    if (wr_en) strobes++;
    @(negedge clk); data_vld = 1'b0; stop_evt = 1'b1;
    if (wr_en) strobes++;
    @(negedge clk); stop_evt = 1'b0;
    if (wr_en) strobes++;
    chk(ptr == held, "R5 ptr ignores load while busy", 32'(ptr), 32'(held));
    while (busy) begin
      @(negedge clk);
      if (wr_en) strobes++;
    end
    @(negedge clk);
    chk(strobes == 0, "R5 no strobe from busy inputs", 32'(strobes), 0);
    chk(ptr == held, "R5 ptr after busy", 32'(ptr), 32'(held));
    chk(wr_en == 1'b0 && busy == 1'b0, "R5 stop while busy ignored", 32'({wr_en, busy}), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_partial();
    t_full();
    t_overflow();
    t_last_off();
    t_dummy();
    t_low();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule